// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides which of two DMA channels owns the bus for the next transfer. Each channel raises a request line and carries a one-bit priority level. If the two levels differ, the channel at the high level always beats the other when both are requesting. If the levels match, a one-bit rotation pointer decides. The pointer names the channel currently favoured. It starts on channel 1. When a channel finishes a transfer, the pointer moves to the other channel, so two channels that keep requesting take turns.

A bus-release indication returns the pointer to channel 1. The surrounding logic asserts it when a destination-synchronized transfer ends or when no request is active. A grant is registered and stays with its owner until one of two things happens: the transfer-done pulse arrives, or the owner's request drops. The grant output is masked by the live request lines, so it never shows a channel that is not requesting.

Top module: `dma_pair_arbiter`

## Requirements
- R1: `grant_o` is one-hot or zero (bit 0 is channel 0, bit 1 is channel 1). It is zero in any cycle where `req_i` is zero.
- R2: After reset, `grant_o` is 2'b00 and `rot_ptr_o` is 1, which favours channel 1.
- R3: If exactly one channel requests at a clock edge, the next cycle grants that channel, whatever the priorities and the pointer.
- R4: If both channels request with different `prio_hi_i` bits at an arbitration edge, the grant goes to the channel whose bit is 1.
- R5: If both channels request with equal `prio_hi_i` bits at an arbitration edge, the grant goes to the channel named by the updated pointer (0 means channel 0, 1 means channel 1).
- R6: On an edge with `xfer_done_i` high, `bus_release_i` low and a grant held, the pointer moves to the channel that did not complete the transfer.
- R7: On an edge with `bus_release_i` high, the pointer becomes 1. This overrides R6.
- R8: While the owner's request stays high and `xfer_done_i` is low, the registered grant does not change.
- R9: Arbitration takes place at any edge where no grant is held, where `xfer_done_i` is high, or where the owner's request is low.
- R10: If both channels request continuously at equal priority and a done pulse comes on each transfer, the grants alternate between the two channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Transfer request, one bit per channel |
| prio_hi_i | input | 2 | Priority level per channel, 1 = high |
| xfer_done_i | input | 1 | Pulse marking the end of the current transfer |
| bus_release_i | input | 1 | Bus released; resets the rotation to channel 1 |
| grant_o | output | 2 | One-hot bus grant, masked by requests |
| rot_ptr_o | output | 1 | Channel currently favoured by rotation |

## Verification
The assertions take all inputs to be synchronous to `clk` and stable around each rising edge. They treat a done pulse with no grant held as having no effect on the pointer. The bench drives every input on the falling edge. It sweeps all request and priority patterns, draws done and release pulses at random, and includes cycles where done and release coincide and cycles with done but no owner. That keeps the stimulus inside these assumptions while still covering each ordering.

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic [1:0] prio_hi_i,
  input  logic       xfer_done_i,
  input  logic       bus_release_i,
  output logic [1:0] grant_o,
  output logic       rot_ptr_o
);

  logic [1:0] gnt_q;
  logic [1:0] gnt_nxt;
  logic       ptr_q;
  logic       ptr_nxt;
  logic       rearb;
  logic       tie;
  logic       win1;

  assign ptr_nxt = bus_release_i ? 1'b1 :
                   (xfer_done_i && gnt_q != 2'b00) ? gnt_q[0] : ptr_q;

  assign rearb = (gnt_q == 2'b00) || xfer_done_i || ((gnt_q & req_i) == 2'b00);
  assign tie   = (prio_hi_i[0] == prio_hi_i[1]);
  assign win1  = tie ? ptr_nxt : prio_hi_i[1];

  always_comb begin
    case (req_i)
      2'b01:   gnt_nxt = 2'b01;
      2'b10:   gnt_nxt = 2'b10;
      2'b11:   gnt_nxt = win1 ? 2'b10 : 2'b01;
      default: gnt_nxt = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= 2'b00;
      ptr_q <= 1'b1;
    end else begin
      ptr_q <= ptr_nxt;
      if (rearb) gnt_q <= gnt_nxt;
    end
  end

  assign grant_o   = gnt_q & req_i;
  assign rot_ptr_o = ptr_q;

endmodule

module dma_pair_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_i,
  input logic [1:0] prio_hi_i,
  input logic       xfer_done_i,
  input logic       bus_release_i,
  input logic [1:0] grant_o,
  input logic       rot_ptr_o,
  input logic [1:0] gnt_q
);

  assert_grant_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (req_i != 2'b00 || grant_o == 2'b00));

  assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 2'b01 || req_i == 2'b10) |=> gnt_q == $past(req_i));

  assert_fixed_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 2'b11 && prio_hi_i[0] != prio_hi_i[1] && (xfer_done_i || gnt_q == 2'b00))
    |=> gnt_q == ($past(prio_hi_i[1]) ? 2'b10 : 2'b01));

  assert_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_i && !bus_release_i && gnt_q != 2'b00) |=> rot_ptr_o == $past(gnt_q[0]));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release_i |=> rot_ptr_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != 2'b00 && !xfer_done_i && (gnt_q & req_i) != 2'b00) |=> gnt_q == $past(gnt_q));

endmodule

bind dma_pair_arbiter dma_pair_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_hi_i(prio_hi_i),
  .xfer_done_i(xfer_done_i), .bus_release_i(bus_release_i),
  .grant_o(grant_o), .rot_ptr_o(rot_ptr_o), .gnt_q(gnt_q)
);

// File: tb/dma_pair_arbiter_tb.sv
module dma_pair_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] req_i, prio_hi_i;
  logic xfer_done_i, bus_release_i;
  logic [1:0] grant_o;
  logic rot_ptr_o;
  int checks = 0, errors = 0;
  int owner = -1;
  logic m_ptr = 1'b1;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_pair_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_hi_i(prio_hi_i),
    .xfer_done_i(xfer_done_i), .bus_release_i(bus_release_i),
    .grant_o(grant_o), .rot_ptr_o(rot_ptr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_grant();
    if (owner < 0) return 2'b00;
    return req_i[owner] ? (2'b01 << owner) : 2'b00;
  endfunction

  task automatic step(input logic [1:0] rq, input logic [1:0] pr, input logic dn,
                      input logic rl, input string tag);
    logic np;
    int cnt;
    @(negedge clk);
    req_i = rq; prio_hi_i = pr; xfer_done_i = dn; bus_release_i = rl;
    #1;
    chk(grant_o == exp_grant(), {tag, " R1 pre-edge"}, grant_o, exp_grant());
    @(posedge clk);
    np = rl ? 1'b1 : (dn && owner >= 0) ? (owner == 0) : m_ptr;
    if (owner < 0 || dn || !rq[owner]) begin
      cnt = rq[0] + rq[1];
      if (cnt == 0) owner = -1;
      else if (cnt == 1) owner = rq[1] ? 1 : 0;
      else if (pr[0] != pr[1]) owner = pr[1] ? 1 : 0;
      else owner = np ? 1 : 0;
    end
    m_ptr = np;
    #1;
    chk(grant_o == exp_grant(), {tag, " grant"}, grant_o, exp_grant());
    chk(rot_ptr_o == m_ptr, {tag, " pointer"}, rot_ptr_o, m_ptr);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = 0; prio_hi_i = 0; xfer_done_i = 0; bus_release_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(grant_o == 2'b00, "R2 reset grant", grant_o, 0);
    chk(rot_ptr_o == 1'b1, "R2 reset pointer", rot_ptr_o, 1);
    rst_n = 1'b1;
    step(2'b11, 2'b00, 0, 0, "R5 first tie picks ch1");
    chk(grant_o == 2'b10, "R5 literal", grant_o, 2);
    step(2'b11, 2'b00, 1, 0, "R6 R10 done ch1");
    chk(grant_o == 2'b01 && rot_ptr_o == 0, "R10 alternate to ch0", grant_o, 1);
    step(2'b11, 2'b00, 1, 0, "R10 done ch0");
    chk(grant_o == 2'b10 && rot_ptr_o == 1, "R10 alternate to ch1", grant_o, 2);
    step(2'b11, 2'b11, 1, 1, "R7 release beats done");
    chk(rot_ptr_o == 1 && grant_o == 2'b10, "R7 literal", rot_ptr_o, 1);
    step(2'b11, 2'b01, 0, 0, "R8 hold under fixed prio");
    chk(grant_o == 2'b10, "R8 literal", grant_o, 2);
    step(2'b11, 2'b01, 1, 0, "R4 high ch0 wins");
    chk(grant_o == 2'b01, "R4 literal", grant_o, 1);
    step(2'b10, 2'b01, 0, 0, "R9 owner drops");
    chk(grant_o == 2'b10, "R3 R9 literal", grant_o, 2);
    step(2'b00, 2'b00, 0, 1, "R1 idle");
    chk(grant_o == 2'b00, "R1 literal", grant_o, 0);
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++)
        for (int d = 0; d < 2; d++)
          for (int b = 0; b < 2; b++)
            step(r[1:0], p[1:0], d[0], b[0], "sweep");
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] pr;
      pr = ($urandom_range(0, 9) == 0) ? 2'($urandom) : prio_hi_i;
      step(2'($urandom), pr, $urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0, "random");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule